// File: doc/BRIEF.md
# Two-Level Priority Match Resolver and Address Encoder

This block takes the per-word match flags of a ternary lookup array and reduces them to a single winner. The winner is the active flag with the lowest index. The flags are split into groups. Each group has its own first-level resolver that keeps only its lowest-index active flag. A second-level resolver chooses the lowest-index group that has any active flag. The combined one-hot winner goes to a binary encoder. The block also reports whether anything matched and whether more than one flag was active.

A block-enable input lets a higher-priority neighbour block silence this one. Three serial test chains support structural testing:
- The first chain can replace the match flags at the first level.
- The second chain can replace the group flags at the second level.
- The third chain can drive the encoder directly.

In test mode the two levels are isolated from each other, so the first level, the second level and the encoder can all be exercised at the same time. All results are registered and appear one clock after the inputs are sampled.

Top module: `prio_match_enc`

## Requirements
- R1: In functional mode (`tst_mode_i`=0) with `blk_en_i`=1, `win_o` is one-hot, and its set bit is the lowest index set in `match_i`. It is all zeros when `match_i` is zero.
- R2: In functional mode, `grp_win_o` has exactly one bit set when any flag is active. That bit is number floor(i/8), where i is the lowest active index and groups are 8 flags wide. The `win_o` bit always lies inside that group.
- R3: When `blk_en_i` is 0, every output (`win_o`, `grp_win_o`, `match_addr_o`, `hit_o`, `multi_o`) is zero on the next cycle, whatever the other inputs are.
- R4: `multi_o` is 1 when more than one bit of the first-level input is set and `blk_en_i` is 1. The first-level input is `match_i` in functional mode and the first-level chain in test mode.
- R5: `match_addr_o` is the binary index of the winning bit. When there is no winner, `match_addr_o` is 0 and `hit_o` is 0.
- R6: Every output reflects the inputs sampled at the previous rising clock edge, with exactly one cycle of latency.
- R7: Each test chain updates on every clock:
  - `clr_i`=1 clears all three chains to zero, and `clr_i` takes priority over `shift_i`.
  - Otherwise, `shift_i`=1 loads each chain's serial input into its highest index (the lowest priority) and moves every bit one place toward index 0.
  - Chain contents have no effect on the outputs in functional mode.
- R8: In test mode, each group's `win_o` slice holds the lowest set bit of that group's slice of the first-level chain, independent of every other group. `grp_win_o` is the one-hot lowest set bit of the second-level chain.
- R9: In test mode, `match_addr_o` is the binary index of the set bit in the encoder chain, and `hit_o` is 1 exactly when the encoder chain is nonzero.
- R10: While `rst_n` is low, all outputs and all chain contents are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| blk_en_i | input | 1 | Block enable; 0 suppresses all results |
| tst_mode_i | input | 1 | 1 selects the test chains and isolates the levels |
| shift_i | input | 1 | Shift all three test chains by one place |
| clr_i | input | 1 | Clear all three test chains (has priority over shift) |
| si_l1_i | input | 1 | Serial input of the first-level chain |
| si_l2_i | input | 1 | Serial input of the second-level chain |
| si_enc_i | input | 1 | Serial input of the encoder chain |
| match_i | input | 128 | Per-word match flags, index 0 has the highest priority |
| win_o | output | 128 | Registered one-hot winner (per-group winners in test mode) |
| grp_win_o | output | 16 | Registered one-hot winning group |
| match_addr_o | output | 7 | Registered binary address of the winner |
| hit_o | output | 1 | Registered any-match flag |
| multi_o | output | 1 | Registered more-than-one-match flag |

## Verification
Every result is due one cycle after the edge that samples its inputs. A change made to a test chain at one edge therefore shows up at the outputs one edge later. The bench keeps a behavioural model that takes the same inputs at each rising edge and holds its predictions for one cycle. It compares all five outputs at the following falling edge, so each comparison lands exactly on the cycle in which the result is due. The stimulus includes:
- single flags, group boundaries and dense patterns;
- enable drops;
- a one-hot walk through the encoder chain;
- a fill of the second-level chain from its lowest-priority end.

// File: rtl/pme_pkg.sv
package pme_pkg;
  localparam int DEF_GRP_W   = 8;
  localparam int DEF_NUM_GRP = 16;

  typedef enum logic [1:0] {
    CH_HOLD  = 2'd0,
    CH_SHIFT = 2'd1,
    CH_CLEAR = 2'd2
  } chain_op_e;
endpackage

// File: rtl/pme_resolver.sv
module pme_resolver #(
  parameter int W = 8
) (
  input  logic [W-1:0] req_i,
  input  logic         en_i,
  output logic [W-1:0] win_o,
  output logic         any_o
);
  logic blocked;

  always_comb begin
    blocked = ~en_i;
    for (int i = 0; i < W; i++) begin
      win_o[i] = req_i[i] & ~blocked;
      blocked  = blocked | req_i[i];
    end
    any_o = en_i & (|req_i);
  end
endmodule

// File: rtl/pme_encoder.sv
module pme_encoder #(
  parameter int W  = 128,
  parameter int AW = $clog2(W)
) (
  input  logic [W-1:0]  onehot_i,
  output logic [AW-1:0] addr_o
);
  always_comb begin
    addr_o = '0;
    for (int i = 0; i < W; i++) begin
      if (onehot_i[i]) addr_o = addr_o | AW'(i);
    end
  end
endmodule

// File: rtl/pme_scan_chain.sv
module pme_scan_chain
  import pme_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  chain_op_e    op_i,
  input  logic         si_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] q_d;
  logic         q_en;

  always_comb begin
    q_en = (op_i != CH_HOLD);
    q_d  = q_o;
    unique case (op_i)
      CH_CLEAR: q_d = '0;
      CH_SHIFT: q_d = {si_i, q_o[W-1:1]};
      default:  q_d = q_o;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q_o <= '0;
    else if (q_en)  q_o <= q_d;
  end
endmodule

// File: rtl/prio_match_enc.sv
module prio_match_enc
  import pme_pkg::*;
#(
  parameter  int GRP_W   = DEF_GRP_W,
  parameter  int NUM_GRP = DEF_NUM_GRP,
  localparam int N       = GRP_W * NUM_GRP,
  localparam int AW      = $clog2(N)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               blk_en_i,
  input  logic               tst_mode_i,
  input  logic               shift_i,
  input  logic               clr_i,
  input  logic               si_l1_i,
  input  logic               si_l2_i,
  input  logic               si_enc_i,
  input  logic [N-1:0]       match_i,
  output logic [N-1:0]       win_o,
  output logic [NUM_GRP-1:0] grp_win_o,
  output logic [AW-1:0]      match_addr_o,
  output logic               hit_o,
  output logic               multi_o
);
  chain_op_e          ch_op;
  logic [N-1:0]       l1_chain_q, enc_chain_q;
  logic [NUM_GRP-1:0] l2_chain_q;

  logic [N-1:0]       l1_in, l1_win, fin_win, enc_in;
  logic [NUM_GRP-1:0] grp_any, l2_in, grp_win;
  logic               top_any;
  logic [AW-1:0]      addr_c;

  logic [N-1:0]       win_d;
  logic [NUM_GRP-1:0] grp_d;
  logic [AW-1:0]      addr_d;
  logic               hit_d, multi_d;

  // test chain control: clear wins over shift
  always_comb begin
    if (clr_i)        ch_op = CH_CLEAR;
    else if (shift_i) ch_op = CH_SHIFT;
    else              ch_op = CH_HOLD;
  end

  pme_scan_chain #(.W(N)) u_l1_chain (
    .clk(clk), .rst_n(rst_n), .op_i(ch_op), .si_i(si_l1_i), .q_o(l1_chain_q));
  pme_scan_chain #(.W(NUM_GRP)) u_l2_chain (
    .clk(clk), .rst_n(rst_n), .op_i(ch_op), .si_i(si_l2_i), .q_o(l2_chain_q));
  pme_scan_chain #(.W(N)) u_enc_chain (
    .clk(clk), .rst_n(rst_n), .op_i(ch_op), .si_i(si_enc_i), .q_o(enc_chain_q));

  // first level: one resolver per group
  assign l1_in = tst_mode_i ? l1_chain_q : match_i;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    pme_resolver #(.W(GRP_W)) u_grp_res (
      .req_i (l1_in[g*GRP_W +: GRP_W]),
      .en_i  (blk_en_i),
      .win_o (l1_win[g*GRP_W +: GRP_W]),
      .any_o (grp_any[g])
    );
    // functional mode: the group winner survives only if its group wins
    assign fin_win[g*GRP_W +: GRP_W] = tst_mode_i ? l1_win[g*GRP_W +: GRP_W]
                                     : l1_win[g*GRP_W +: GRP_W] & {GRP_W{grp_win[g]}};
  end

  // second level: arbitration among groups
  assign l2_in = tst_mode_i ? l2_chain_q : grp_any;

  pme_resolver #(.W(NUM_GRP)) u_top_res (
    .req_i (l2_in),
    .en_i  (blk_en_i),
    .win_o (grp_win),
    .any_o (top_any)
  );

  // encoder input: resolver result, or the encoder chain in test mode
  assign enc_in = tst_mode_i ? (enc_chain_q & {N{blk_en_i}}) : fin_win;

  pme_encoder #(.W(N), .AW(AW)) u_enc (
    .onehot_i (enc_in),
    .addr_o   (addr_c)
  );

  // next state of the output registers
  always_comb begin
    win_d   = fin_win;
    grp_d   = grp_win;
    addr_d  = addr_c;
    hit_d   = tst_mode_i ? (|enc_in) : top_any;
    multi_d = blk_en_i & ((l1_in & (l1_in - N'(1))) != '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_o        <= '0;
      grp_win_o    <= '0;
      match_addr_o <= '0;
      hit_o        <= 1'b0;
      multi_o      <= 1'b0;
    end else begin
      win_o        <= win_d;
      grp_win_o    <= grp_d;
      match_addr_o <= addr_d;
      hit_o        <= hit_d;
      multi_o      <= multi_d;
    end
  end
endmodule

// File: rtl/pme_checker.sv
module pme_checker #(
  parameter int N       = 128,
  parameter int NUM_GRP = 16,
  parameter int AW      = 7
) (
  input logic               clk,
  input logic               rst_n,
  input logic               blk_en_i,
  input logic               tst_mode_i,
  input logic               shift_i,
  input logic               clr_i,
  input logic               si_l2_i,
  input logic [N-1:0]       match_i,
  input logic [N-1:0]       win_o,
  input logic [NUM_GRP-1:0] grp_win_o,
  input logic [AW-1:0]      match_addr_o,
  input logic               hit_o,
  input logic               multi_o,
  input logic [N-1:0]       l1_q,
  input logic [NUM_GRP-1:0] l2_q,
  input logic [N-1:0]       enc_q
);
  AST_WIN_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    !tst_mode_i |=> $onehot0(win_o)); // R1

  AST_GRP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grp_win_o)); // R2

  AST_BLK_SUPPRESS: assert property (@(posedge clk) disable iff (!rst_n)
    !blk_en_i |=> (win_o == '0 && grp_win_o == '0 && match_addr_o == '0 && !hit_o && !multi_o)); // R3

  AST_MULTI_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    !tst_mode_i |=> (!multi_o || hit_o)); // R4

  AST_NO_HIT_ADDR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !hit_o |-> match_addr_o == '0); // R5

  AST_HIT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (!tst_mode_i && blk_en_i && match_i != '0) |=> hit_o); // R6

  AST_CHAIN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (l1_q == '0 && l2_q == '0 && enc_q == '0)); // R7

  AST_CHAIN_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_i && !clr_i) |=> l2_q[NUM_GRP-1] == $past(si_l2_i)); // R7
endmodule

bind prio_match_enc pme_checker #(.N(N), .NUM_GRP(NUM_GRP), .AW(AW)) u_pme_checker (
  .clk(clk), .rst_n(rst_n), .blk_en_i(blk_en_i), .tst_mode_i(tst_mode_i),
  .shift_i(shift_i), .clr_i(clr_i), .si_l2_i(si_l2_i), .match_i(match_i),
  .win_o(win_o), .grp_win_o(grp_win_o), .match_addr_o(match_addr_o),
  .hit_o(hit_o), .multi_o(multi_o),
  .l1_q(l1_chain_q), .l2_q(l2_chain_q), .enc_q(enc_chain_q)
);

// File: tb/test_prio_match_enc.sv
`timescale 1ns/1ps
module test_prio_match_enc;
  localparam int GW = 8;
  localparam int NG = 16;
  localparam int N  = GW * NG;
  localparam int AW = 7;

  logic clk = 1'b0;
  logic rst_n;
  logic blk_en, tst, sh, cl, s1, s2, s3;
  logic [N-1:0]  match;
  logic [N-1:0]  win;
  logic [NG-1:0] grp;
  logic [AW-1:0] addr;
  logic hit, multi;

  always #2 clk = ~clk;

  prio_match_enc i_prio_match_enc (
    .clk(clk), .rst_n(rst_n), .blk_en_i(blk_en), .tst_mode_i(tst),
    .shift_i(sh), .clr_i(cl), .si_l1_i(s1), .si_l2_i(s2), .si_enc_i(s3),
    .match_i(match), .win_o(win), .grp_win_o(grp), .match_addr_o(addr),
    .hit_o(hit), .multi_o(multi));

  int n_chk = 0;
  int n_fail = 0;
  string cur_req = "R10";
  bit started = 0;

  // reference model state
  logic [N-1:0]  m_l1, m_enc, e_win;
  logic [NG-1:0] m_l2, e_grp;
  logic [AW-1:0] e_addr;
  logic e_hit, e_multi;

  function automatic int lowest(input logic [N-1:0] v, input int lo, input int hi);
    for (int i = lo; i <= hi; i++) if (v[i]) return i;
    return -1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_l1 = '0; m_l2 = '0; m_enc = '0;
      e_win = '0; e_grp = '0; e_addr = '0; e_hit = 0; e_multi = 0;
    end else begin
      e_win = '0; e_grp = '0; e_addr = '0; e_hit = 0; e_multi = 0;
      if (blk_en) begin
        if (!tst) begin
          int w;
          w = lowest(match, 0, N-1);
          if (w >= 0) begin
            e_win[w] = 1'b1;
            e_grp[w / GW] = 1'b1;
            e_addr = AW'(w);
            e_hit = 1'b1;
          end
          e_multi = ($countones(match) > 1);
        end else begin
          int gidx;
          for (int g = 0; g < NG; g++) begin
            int w;
            w = lowest(m_l1, g*GW, g*GW + GW - 1);
            if (w >= 0) e_win[w] = 1'b1;
          end
          gidx = lowest({{(N-NG){1'b0}}, m_l2}, 0, NG-1);
          if (gidx >= 0) e_grp[gidx] = 1'b1;
          for (int i = 0; i < N; i++) if (m_enc[i]) e_addr = e_addr | AW'(i);
          e_hit = (m_enc != '0);
          e_multi = ($countones(m_l1) > 1);
        end
      end
      if (cl) begin
        m_l1 = '0; m_l2 = '0; m_enc = '0;
      end else if (sh) begin
        m_l1  = {s1, m_l1[N-1:1]};
        m_l2  = {s2, m_l2[NG-1:1]};
        m_enc = {s3, m_enc[N-1:1]};
      end
    end
  end

  task automatic chk1(input string what, input logic [N-1:0] act, input logic [N-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (started) begin
      chk1("win_o", win, e_win);
      chk1("grp_win_o", N'(grp), N'(e_grp));
      chk1("match_addr_o", N'(addr), N'(e_addr));
      chk1("hit_o", N'(hit), N'(e_hit));
      chk1("multi_o", N'(multi), N'(e_multi));
    end
  end

  task automatic drive(input logic [N-1:0] m);
    @(negedge clk);
    match = m;
    @(posedge clk);
  endtask

  task automatic shift_all(input logic a, input logic b, input logic c);
    @(negedge clk);
    sh = 1; s1 = a; s2 = b; s3 = c;
    @(posedge clk);
    @(negedge clk);
    sh = 0; s1 = 0; s2 = 0; s3 = 0;
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; blk_en = 1; tst = 0; sh = 0; cl = 0; s1 = 0; s2 = 0; s3 = 0;
    match = '1;
    started = 1;
    // R10: outputs held at zero while reset is low
    cur_req = "R10";
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    match = '0;
    @(posedge clk);

    // R1: lowest index wins
    cur_req = "R1";
    drive(N'(1) << 0);
    drive(N'(1) << 5);
    drive(N'(1) << 127);
    drive((N'(1) << 41) | (N'(1) << 40));
    drive((N'(1) << 90) | (N'(1) << 3) | (N'(1) << 127));

    // R2: group arbitration and boundaries
    cur_req = "R2";
    drive((N'(1) << 7) | (N'(1) << 8));
    drive((N'(1) << 8) | (N'(1) << 15));
    drive((N'(1) << 64) | (N'(1) << 100));
    drive({8'hff, {(N-8){1'b0}}});

    // R4: multi-match flag
    cur_req = "R4";
    drive(N'(1) << 77);
    drive((N'(1) << 77) | (N'(1) << 78));
    drive('1);

    // R5: no match gives zero address and no hit
    cur_req = "R5";
    drive('0);

    // R3: block disable suppresses everything
    cur_req = "R3";
    @(negedge clk);
    blk_en = 0;
    drive('1);
    drive(N'(1) << 9);
    @(negedge clk);
    blk_en = 1;
    drive(N'(1) << 9);

    // R6: one-cycle latency under changing inputs
    cur_req = "R6";
    for (int k = 0; k < 20; k++) drive(N'(1) << ((k * 37) % N) | (N'(1) << 120));

    // R7: chains load without touching functional outputs, clear wins over shift
    cur_req = "R7";
    @(negedge clk); match = N'(1) << 50;
    for (int k = 0; k < 6; k++) shift_all(1'b1, 1'b1, 1'b1);
    @(negedge clk); cl = 1; sh = 1; s1 = 1; s2 = 1; s3 = 1;
    @(posedge clk);
    @(negedge clk); cl = 0; sh = 0; s1 = 0; s2 = 0; s3 = 0; tst = 1;
    repeat (2) @(posedge clk);

    // R9: walk a single one through the encoder chain
    cur_req = "R9";
    shift_all(1'b0, 1'b0, 1'b1);
    for (int k = 1; k < N; k++) shift_all(1'b0, 1'b0, 1'b0);
    shift_all(1'b0, 1'b0, 1'b0);

    // R8: fill the second-level chain from its lowest-priority end; load first level
    cur_req = "R8";
    @(negedge clk); cl = 1;
    @(posedge clk);
    @(negedge clk); cl = 0;
    for (int k = 0; k < NG; k++) shift_all(1'b0, 1'b1, 1'b0);
    for (int k = 0; k < N; k++) shift_all(((k % 11) == 0) || ((k % 13) == 0), 1'b0, 1'b0);
    @(negedge clk); blk_en = 0;
    @(posedge clk);
    @(negedge clk); blk_en = 1;
    repeat (2) @(posedge clk);

    @(negedge clk);
    finish_run();
  end
endmodule